// File: doc/BRIEF.md
# Read-Index Mirror Writer

This block keeps a copy of every copy engine's ring read index in host memory. The target's own index registers can sit in a power domain that collapses when idle. Host software therefore reads the copy from memory and never touches a register that might be unclocked. Each engine owns one half-word slot in a memory region whose base is programmed through a small configuration port. Whenever an engine reports a new read index, the block writes that value into the engine's slot.

Updates are latched per engine as a pending flag plus the latest value. A round-robin arbiter chooses which pending engine is written next. A single-outstanding memory write port issues the request and holds it until the memory acknowledges it. When an engine's index moves several times before its write goes out, the intermediate values are dropped and only the newest one is written. A control bit enables the whole mirror. Clearing that bit discards whatever is still pending.

Top module: `read_index_mirror`

## Requirements
- R1: After reset, `mem_req` is low, the enable bit is clear and the base register is zero, so no update leads to a memory write until software enables the block.
- R2: A configuration write with `cfg_sel`=0 loads `cfg_wdata` as the region base. A write with `cfg_sel`=1 loads `cfg_wdata[0]` as the enable bit. While enable is clear, update strobes are ignored and leave nothing pending.
- R3: Each write to engine i uses byte address base + 2*i (modulo 2^ADDR_W) and carries that engine's IDX_W-bit read index on `mem_data`.
- R4: At most one write is outstanding. Once `mem_req` rises, it stays high with `mem_addr` and `mem_data` unchanged until the cycle in which `mem_ack` is high.
- R5: If an engine's index is updated more than once before its write is issued, exactly one write is made for that engine, and it carries the last value.
- R6: After a write to engine k is issued, the next write goes to the first pending engine in the order k+1, k+2, …, wrapping past NUM_ENG-1 to 0. After reset the search starts at engine 0.
- R7: Clearing the enable bit discards every pending update, and re-enabling does not bring them back. A write already on the port still completes.
- R8: An update sampled at clock edge t raises `mem_req` after edge t+1 when the port is idle. After an acknowledge at edge j, the next pending write raises `mem_req` after edge j+1.
- R9: An update to an engine sampled at the same edge on which that engine's write is issued does not alter the issued write. Instead, it produces one further write carrying the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the base register, 1 selects the control register |
| cfg_wdata | input | ADDR_W | Configuration write data |
| upd_valid | input | NUM_ENG | Per-engine read-index change strobe |
| upd_idx | input | NUM_ENG*IDX_W | Per-engine new read index; engine i occupies bits [i*IDX_W +: IDX_W] |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Byte address of the slot being written |
| mem_data | output | IDX_W | Read index being written |
| mem_ack | input | 1 | Memory write acknowledge |

## Verification
The hardest cases to reach from the ports are those where updates pile up behind a slow memory. These include coalescing of repeated updates, the order in which a backlog drains, and dropping a backlog when the block is disabled. The bench provokes them by withholding `mem_ack` from its memory responder. While the acknowledge is withheld, it fires single, repeated and all-engine updates. It then releases the acknowledge and compares the logged write sequence with the order and values computed from the arbitration rule. The collision between an update and the issue of the same engine is placed by driving the second update exactly one cycle after the first.

// File: rtl/rim_pkg.sv
package rim_pkg;

   // Configuration register select
   typedef enum logic {
      CFG_BASE = 1'b0,
      CFG_CTRL = 1'b1
   } cfg_sel_e;

   // Bit position of the enable flag in the control register
   localparam int CTRL_EN_BIT = 0;

   // Arbitration variants
   localparam int ARB_FIXED = 0;
   localparam int ARB_ROUND_ROBIN = 1;

endpackage

// File: rtl/rim_cfg_regs.sv
module rim_cfg_regs
   import rim_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [ADDR_W-1:0] cfg_wdata,
   output logic [ADDR_W-1:0] base_q,
   output logic              en_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         en_q   <= 1'b0;
      end else if (cfg_we) begin
         if (cfg_sel_e'(cfg_sel) == CFG_BASE) begin
            base_q <= cfg_wdata;
         end else begin
            en_q <= cfg_wdata[CTRL_EN_BIT];
         end
      end
   end

endmodule

// File: rtl/rim_slot_bank.sv
module rim_slot_bank #(
   parameter int NUM_ENG = 12,
   parameter int IDX_W   = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     en,
   input  logic [NUM_ENG-1:0]       upd_valid,
   input  logic [NUM_ENG*IDX_W-1:0] upd_idx,
   input  logic [NUM_ENG-1:0]       take_vec,
   output logic [NUM_ENG-1:0]       pend,
   output logic [NUM_ENG*IDX_W-1:0] val_flat
);

   for (genvar g = 0; g < NUM_ENG; g++) begin : g_slot
      logic             pend_q;
      logic [IDX_W-1:0] val_q;

      // Newest value always overwrites; issue clears the flag unless a
      // fresh update lands on the same edge.
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend_q <= 1'b0;
            val_q  <= '0;
         end else if (!en) begin
            pend_q <= 1'b0;
         end else if (upd_valid[g]) begin
            pend_q <= 1'b1;
            val_q  <= upd_idx[g*IDX_W +: IDX_W];
         end else if (take_vec[g]) begin
            pend_q <= 1'b0;
         end
      end

      assign pend[g] = pend_q;
      assign val_flat[g*IDX_W +: IDX_W] = val_q;
   end

endmodule

// File: rtl/rim_rr_arb.sv
module rim_rr_arb
   import rim_pkg::*;
#(
   parameter int NUM_ENG = 12,
   parameter int ARB_KIND = ARB_ROUND_ROBIN,
   localparam int ENG_W = $clog2(NUM_ENG)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_ENG-1:0] req,
   input  logic               adv,
   output logic [NUM_ENG-1:0] gnt,
   output logic [ENG_W-1:0]   gnt_idx,
   output logic               gnt_any
);

   logic [NUM_ENG-1:0] cand;

   if (ARB_KIND == ARB_ROUND_ROBIN) begin : g_rr
      logic [ENG_W-1:0]   last_q;
      logic [NUM_ENG-1:0] upper;

      always_comb begin
         for (int i = 0; i < NUM_ENG; i++) begin
            upper[i] = req[i] && (i > int'(last_q));
         end
         cand = (|upper) ? upper : req;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            last_q <= ENG_W'(NUM_ENG - 1);
         end else if (adv && gnt_any) begin
            last_q <= gnt_idx;
         end
      end
   end else begin : g_fixed
      assign cand = req;
   end

   // Lowest set bit of the candidate set
   always_comb begin
      gnt     = '0;
      gnt_idx = '0;
      for (int i = NUM_ENG - 1; i >= 0; i--) begin
         if (cand[i]) begin
            gnt     = '0;
            gnt[i]  = 1'b1;
            gnt_idx = ENG_W'(i);
         end
      end
      gnt_any = |cand;
   end

endmodule

// File: rtl/rim_wr_port.sv
module rim_wr_port #(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 16,
   parameter int ENG_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  logic [ENG_W-1:0]  eng,
   input  logic [ADDR_W-1:0] base,
   input  logic [IDX_W-1:0]  data,
   input  logic              mem_ack,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [IDX_W-1:0]  mem_data,
   output logic              busy
);

   logic [ADDR_W-1:0] slot_off;

   // Half-word slots: byte offset is twice the engine number
   assign slot_off = ADDR_W'(eng) << 1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_req  <= 1'b0;
         mem_addr <= '0;
         mem_data <= '0;
      end else if (mem_req) begin
         if (mem_ack) begin
            mem_req <= 1'b0;
         end
      end else if (issue) begin
         mem_req  <= 1'b1;
         mem_addr <= base + slot_off;
         mem_data <= data;
      end
   end

   assign busy = mem_req;

endmodule

// File: rtl/read_index_mirror.sv
module read_index_mirror
   import rim_pkg::*;
#(
   parameter int NUM_ENG  = 12,
   parameter int IDX_W    = 16,
   parameter int ADDR_W   = 32,
   parameter int ARB_KIND = ARB_ROUND_ROBIN
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_we,
   input  logic                     cfg_sel,
   input  logic [ADDR_W-1:0]        cfg_wdata,
   input  logic [NUM_ENG-1:0]       upd_valid,
   input  logic [NUM_ENG*IDX_W-1:0] upd_idx,
   output logic                     mem_req,
   output logic [ADDR_W-1:0]        mem_addr,
   output logic [IDX_W-1:0]         mem_data,
   input  logic                     mem_ack
);

   localparam int ENG_W = $clog2(NUM_ENG);

   // Elaboration-time parameter checks
   if (NUM_ENG < 2) begin : g_chk_eng
      $error("read_index_mirror: NUM_ENG must be at least 2");
   end
   if (IDX_W < 1 || IDX_W > 16) begin : g_chk_idx
      $error("read_index_mirror: IDX_W must fit a half-word slot");
   end
   if (ADDR_W < ENG_W + 2) begin : g_chk_addr
      $error("read_index_mirror: ADDR_W too narrow for the region");
   end
   if (ARB_KIND != ARB_FIXED && ARB_KIND != ARB_ROUND_ROBIN) begin : g_chk_arb
      $error("read_index_mirror: unknown ARB_KIND");
   end

   logic [ADDR_W-1:0]        base_q;
   logic                     en_q;
   logic [NUM_ENG-1:0]       pend_vec;
   logic [NUM_ENG*IDX_W-1:0] val_flat;
   logic [NUM_ENG-1:0]       gnt_vec;
   logic [ENG_W-1:0]         gnt_idx;
   logic                     gnt_any;
   logic                     port_busy;
   logic                     take;
   logic [NUM_ENG-1:0]       take_vec;
   logic [IDX_W-1:0]         sel_val;

   rim_cfg_regs #(.ADDR_W(ADDR_W)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_sel  (cfg_sel),
      .cfg_wdata(cfg_wdata),
      .base_q   (base_q),
      .en_q     (en_q)
   );

   rim_slot_bank #(.NUM_ENG(NUM_ENG), .IDX_W(IDX_W)) u_slots (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en_q),
      .upd_valid(upd_valid),
      .upd_idx  (upd_idx),
      .take_vec (take_vec),
      .pend     (pend_vec),
      .val_flat (val_flat)
   );

   rim_rr_arb #(.NUM_ENG(NUM_ENG), .ARB_KIND(ARB_KIND)) u_arb (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (pend_vec),
      .adv    (take),
      .gnt    (gnt_vec),
      .gnt_idx(gnt_idx),
      .gnt_any(gnt_any)
   );

   assign take     = gnt_any && en_q && !port_busy;
   assign take_vec = take ? gnt_vec : '0;
   assign sel_val  = val_flat[gnt_idx*IDX_W +: IDX_W];

   rim_wr_port #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ENG_W(ENG_W)) u_port (
      .clk     (clk),
      .rst_n   (rst_n),
      .issue   (take),
      .eng     (gnt_idx),
      .base    (base_q),
      .data    (sel_val),
      .mem_ack (mem_ack),
      .mem_req (mem_req),
      .mem_addr(mem_addr),
      .mem_data(mem_data),
      .busy    (port_busy)
   );

endmodule

// File: rtl/rim_chk.sv
module rim_chk #(
   parameter int NUM_ENG = 12,
   parameter int IDX_W   = 16,
   parameter int ADDR_W  = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               en_q,
   input logic [NUM_ENG-1:0] pend,
   input logic [NUM_ENG-1:0] gnt,
   input logic               mem_req,
   input logic               mem_ack,
   input logic [ADDR_W-1:0]  mem_addr,
   input logic [IDX_W-1:0]   mem_data
);

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> mem_req); // R4

   AST_PAYLOAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> ($stable(mem_addr) && $stable(mem_data))); // R4

   AST_ISSUE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req) |-> $past(en_q)); // R2

   AST_DISABLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> (pend == '0)); // R7

   AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt)); // R6

   AST_GNT_FROM_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt != '0) |-> ((gnt & ~pend) == '0)); // R6

endmodule

bind read_index_mirror rim_chk #(
   .NUM_ENG(NUM_ENG),
   .IDX_W  (IDX_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .en_q    (en_q),
   .pend    (pend_vec),
   .gnt     (gnt_vec),
   .mem_req (mem_req),
   .mem_ack (mem_ack),
   .mem_addr(mem_addr),
   .mem_data(mem_data)
);

// File: tb/tb_read_index_mirror.sv
module tb_read_index_mirror;

   localparam int NE = 12;
   localparam int IW = 16;
   localparam int AW = 32;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_we = 1'b0;
   logic             cfg_sel = 1'b0;
   logic [AW-1:0]    cfg_wdata = '0;
   logic [NE-1:0]    upd_valid = '0;
   logic [NE*IW-1:0] upd_idx = '0;
   logic             mem_req;
   logic [AW-1:0]    mem_addr;
   logic [IW-1:0]    mem_data;
   logic             mem_ack = 1'b0;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;
   bit stall = 1'b0;

   logic [AW-1:0] lg_addr [0:63];
   logic [IW-1:0] lg_data [0:63];
   int lg_n = 0;
   logic [AW-1:0] base_cur = '0;

   read_index_mirror #(.NUM_ENG(NE), .IDX_W(IW), .ADDR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .upd_valid(upd_valid), .upd_idx(upd_idx),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data),
      .mem_ack(mem_ack)
   );

   always #10 clk = ~clk; // 50 MHz

   // Memory responder: acks one cycle at a time, logs every accepted write
   initial begin
      forever begin
         @(negedge clk);
         if (mem_ack) begin
            mem_ack = 1'b0;
         end else if (mem_req && !stall) begin
            mem_ack = 1'b1;
            if (lg_n < 64) begin
               lg_addr[lg_n] = mem_addr;
               lg_data[lg_n] = mem_data;
            end
            lg_n++;
         end
      end
   end

   task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                      input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] slot_addr(input int e);
      return base_cur + AW'(2 * e);
   endfunction

   task automatic cfg_write(input logic sel, input logic [AW-1:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      if (sel == 1'b0) base_cur = d;
   endtask

   task automatic upd_mask(input logic [NE-1:0] m, input logic [IW-1:0] salt);
      @(negedge clk);
      upd_valid = m;
      for (int i = 0; i < NE; i++) upd_idx[i*IW +: IW] = salt + IW'(i);
      @(negedge clk);
      upd_valid = '0;
   endtask

   task automatic upd_one(input int e, input logic [IW-1:0] v);
      @(negedge clk);
      upd_valid = '0;
      upd_valid[e] = 1'b1;
      upd_idx[e*IW +: IW] = v;
      @(negedge clk);
      upd_valid = '0;
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk_entry(input int k, input int e, input logic [IW-1:0] v,
                            input string rq);
      chk(lg_addr[k] == slot_addr(e), rq, lg_addr[k], slot_addr(e));
      chk(lg_data[k] == v, rq, 32'(lg_data[k]), 32'(v));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      settle(3);
      rst_n = 1'b1;
      settle(2);
      // R1: reset state, disabled after reset
      chk(mem_req == 1'b0, "R1 req low", 32'(mem_req), 0);
      upd_one(0, 16'h1234);
      settle(8);
      chk(lg_n == 0, "R1 no write before enable", lg_n, 0);

      cfg_write(1'b0, 32'h0000_1000);
      cfg_write(1'b1, 32'h1);

      // R3: sweep every engine, several values, two bases (one wraps)
      for (int b = 0; b < 2; b++) begin
         if (b == 1) cfg_write(1'b0, 32'hFFFF_FFF4);
         for (int e = 0; e < NE; e++) begin
            for (int s = 0; s < 3; s++) begin
               logic [IW-1:0] v;
               v = (s == 0) ? 16'h0000 : (s == 1) ? 16'hFFFF : IW'(e * 16'h1111 + 7);
               lg_n = 0;
               upd_one(e, v);
               settle(6);
               chk(lg_n == 1, "R3 one write", lg_n, 1);
               chk_entry(0, e, v, "R3 addr/data");
            end
         end
      end
      cfg_write(1'b0, 32'h0000_2000);

      // R8 and R4: latency, hold under stall, gap after ack
      stall = 1'b1;
      lg_n = 0;
      @(negedge clk);
      upd_valid = '0; upd_valid[6] = 1'b1; upd_idx[6*IW +: IW] = 16'h0606;
      @(negedge clk);
      upd_valid = '0;
      chk(mem_req == 1'b0, "R8 not yet", 32'(mem_req), 0);
      @(negedge clk);
      chk(mem_req == 1'b1, "R8 req after two edges", 32'(mem_req), 1);
      chk(mem_addr == slot_addr(6), "R8 addr", mem_addr, slot_addr(6));
      upd_one(9, 16'h0909);
      settle(5);
      chk(mem_req == 1'b1, "R4 req held", 32'(mem_req), 1);
      chk(mem_addr == slot_addr(6), "R4 addr held", mem_addr, slot_addr(6));
      chk(mem_data == 16'h0606, "R4 data held", 32'(mem_data), 32'h0606);
      stall = 1'b0;
      @(posedge clk iff mem_ack);
      @(negedge clk);
      chk(mem_req == 1'b0, "R8 idle cycle after ack", 32'(mem_req), 0);
      @(negedge clk);
      chk(mem_req == 1'b1, "R8 next req", 32'(mem_req), 1);
      chk(mem_addr == slot_addr(9), "R4 single outstanding next engine", mem_addr, slot_addr(9));
      settle(6);
      chk(lg_n == 2, "R4 two writes", lg_n, 2);

      // R5: coalescing under stall
      stall = 1'b1;
      lg_n = 0;
      upd_one(2, 16'h000A);
      upd_one(5, 16'h0011);
      upd_one(5, 16'h0022);
      upd_one(5, 16'h0033);
      settle(2);
      stall = 1'b0;
      settle(12);
      chk(lg_n == 2, "R5 coalesced count", lg_n, 2);
      chk_entry(0, 2, 16'h000A, "R5 first");
      chk_entry(1, 5, 16'h0033, "R5 newest value");

      // R9: update colliding with issue of same engine
      lg_n = 0;
      @(negedge clk);
      upd_valid = '0; upd_valid[4] = 1'b1; upd_idx[4*IW +: IW] = 16'h0100;
      @(negedge clk);
      upd_idx[4*IW +: IW] = 16'h0200;
      @(negedge clk);
      upd_valid = '0;
      settle(10);
      chk(lg_n == 2, "R9 two writes", lg_n, 2);
      chk_entry(0, 4, 16'h0100, "R9 old value issued");
      chk_entry(1, 4, 16'h0200, "R9 new value follows");

      // R6: pointer continues after last grant (4 -> 6 -> 2)
      stall = 1'b1;
      lg_n = 0;
      upd_one(4, 16'h0444);
      upd_mask(12'b0000_0100_0100, 16'h0700);
      settle(2);
      stall = 1'b0;
      settle(12);
      chk(lg_n == 3, "R6 count", lg_n, 3);
      chk_entry(0, 4, 16'h0444, "R6 order 0");
      chk_entry(1, 6, 16'h0706, "R6 order 1");
      chk_entry(2, 2, 16'h0702, "R6 order 2");

      // R6: full backlog drains in rotation and wraps
      stall = 1'b1;
      lg_n = 0;
      upd_one(0, 16'h0050);
      upd_mask({NE{1'b1}}, 16'h0060);
      settle(2);
      stall = 1'b0;
      settle(40);
      chk(lg_n == NE + 1, "R6 backlog count", lg_n, NE + 1);
      chk_entry(0, 0, 16'h0050, "R6 backlog head");
      for (int k = 1; k <= NE; k++) begin
         int e;
         e = k % NE;
         chk_entry(k, e, 16'h0060 + IW'(e), "R6 backlog order");
      end

      // R7: disable drops pending, outstanding write completes
      stall = 1'b1;
      lg_n = 0;
      upd_one(3, 16'h0333);
      upd_mask(12'b0001_1000_0000, 16'h0800);
      cfg_write(1'b1, 32'h0);
      stall = 1'b0;
      settle(10);
      chk(lg_n == 1, "R7 only in-flight write", lg_n, 1);
      chk_entry(0, 3, 16'h0333, "R7 in-flight entry");
      cfg_write(1'b1, 32'h1);
      settle(10);
      chk(lg_n == 1, "R7 dropped stay dropped", lg_n, 1);

      // R2: updates ignored while disabled, base reprogramming
      cfg_write(1'b1, 32'h0);
      lg_n = 0;
      upd_one(1, 16'h0111);
      settle(10);
      chk(mem_req == 1'b0, "R2 no req while disabled", 32'(mem_req), 0);
      chk(lg_n == 0, "R2 no write while disabled", lg_n, 0);
      cfg_write(1'b1, 32'hFFFF_FFFE);
      settle(10);
      chk(lg_n == 0, "R2 enable bit 0 only, nothing latched", lg_n, 0);
      cfg_write(1'b1, 32'h1);
      settle(10);
      chk(lg_n == 0, "R2 ignored update not replayed", lg_n, 0);
      cfg_write(1'b0, 32'h0000_3000);
      upd_one(11, 16'hBEEF);
      settle(8);
      chk(lg_n == 1, "R2 write after base change", lg_n, 1);
      chk_entry(0, 11, 16'hBEEF, "R2 new base used");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule